// File: doc/BRIEF.md
# Rejected Interrupt Replay Bitmap

This block keeps a record of interrupts that the downstream presenter turned away and plays them back on request. Each rejected source is held as one bit in a bank of words, and a second, narrower vector marks which words hold at least one set bit. A replay scan uses that marker vector to skip empty words. It works through the flagged words from the lowest to the highest. Inside each word it takes the set bits from the lowest to the highest.

A reject arrives as a global interrupt number. The block subtracts a configured base number to get a local source index. Numbers that fall below the base, or past the last source the bitmap holds, are dropped. A replay request starts a scan. Every recorded source leaves through a valid/ready handshake toward a dispatcher, with a force flag telling the dispatcher to send it whatever its pending/queued state is. Each marker bit and each source bit is cleared just before the work it stands for is done.

A reject may arrive while a scan is running. If it lands in a word the scan has not reached yet, it is replayed in the same scan. If it lands in a word the scan has already passed, it waits for the next request.

Top module: `reject_replay`

## Requirements
- R1: A reject with global number g, where n = g - base satisfies 0 <= n < 2048, records source n as bit n mod 64 of word n/64 and marks word n/64. The next replay scan emits it as out_src = n, where out_src[10:6] is the word and out_src[5:0] is the bit.
- R2: A reject with g < base, or with g - base >= 2048, is ignored: a following replay scan emits nothing for it.
- R3: A replay request while no word is marked emits nothing. busy is high for exactly one cycle after the request and then low.
- R4: A scan emits the recorded sources in ascending order, each source once, and clears them. A second request right after emits nothing for those sources.
- R5: out_force is 1 on every emitted source.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_src stays unchanged. The scan resumes at the same source once out_ready rises.
- R7: A reject arriving during a scan, in a word above the word being scanned, is emitted in the same scan. A reject in a word at or below a word already left waits for the next request.
- R8: A reject of the source whose bit the scanner clears in that same cycle is kept. The source is emitted a second time within the same scan.
- R9: A replay request while busy is 1 is ignored and does not restart the scan.
- R10: Synchronous active-low reset clears every recorded source and every word mark. It drives out_valid and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_irq | input | 24 | Global number of local source 0 |
| rej_valid | input | 1 | A reject is presented this cycle |
| rej_irq | input | 24 | Global number of the rejected interrupt |
| resend_req | input | 1 | Start a replay scan (one-cycle pulse) |
| out_ready | input | 1 | Dispatcher accepts the presented source |
| out_valid | output | 1 | A replayed source is presented |
| out_src | output | 11 | Local source index being replayed |
| out_force | output | 1 | Send regardless of pending/queued state |
| busy | output | 1 | A replay scan is in progress |

## Verification
The two functions that can meet in one cycle are a new reject and the scanner's clear of that same source bit. The same is true of a reject and the clear of a word's mark. The bench times a reject of the only recorded source into the exact cycle the scanner picks that bit, counted from the request edge. It expects the source to appear twice in that scan, with the following scan empty. The bench also stalls the dispatcher while injecting rejects below and above the current word and pulsing a new request. It judges the result by the exact order of the emitted sources.

// File: rtl/rr_pkg.sv
// Package rr_pkg
// Shared types for the reject replay block. Assumes nothing beyond 1800-2017.
package rr_pkg;
    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,   // waiting for a replay request
        SCAN_WORD = 2'd1,   // choosing the next marked word
        SCAN_BIT  = 2'd2,   // choosing the next set bit of the word
        SCAN_EMIT = 2'd3    // presenting one source to the dispatcher
    } scan_state_e;
endpackage

// File: rtl/rr_lowfind.sv
// Module rr_lowfind
// Finds the lowest set bit of a vector. Purely combinational.
// Assumes W is at least 2 so that the index width is non-zero.
module rr_lowfind #(
    parameter int W = 64,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Priority scan from the top so the lowest set bit is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rr_decode.sv
// Module rr_decode
// Turns a global interrupt number into a local source index and flags
// whether it lies inside the bitmap. Combinational.
// Assumes IRQ_W is wider than SRC_W.
module rr_decode #(
    parameter int IRQ_W     = 24,
    parameter int SRC_COUNT = 2048,
    localparam int SRC_W    = $clog2(SRC_COUNT)
) (
    input  logic             valid,
    input  logic [IRQ_W-1:0] base,
    input  logic [IRQ_W-1:0] irq,
    output logic             hit,
    output logic [SRC_W-1:0] src
);
    logic [IRQ_W:0] diff;

    // Subtract with a borrow bit, then bound-check the local index.
    always_comb begin
        diff = {1'b0, irq} - {1'b0, base};
        hit  = valid && !diff[IRQ_W] && (diff[IRQ_W-1:0] < IRQ_W'(SRC_COUNT));
        src  = diff[SRC_W-1:0];
    end
endmodule

// File: rtl/rr_bitmap.sv
// Module rr_bitmap
// Two-level record: WORDS words of WBITS bits plus one mark bit per word.
// Within one cycle a set takes priority over a clear of the same bit.
// Assumes WORDS and WBITS are powers of two.
module rr_bitmap #(
    parameter int WORDS = 32,
    parameter int WBITS = 64,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int BIDX_W = $clog2(WBITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [WIDX_W-1:0] set_w,
    input  logic [BIDX_W-1:0] set_b,
    input  logic              clr_en,
    input  logic [WIDX_W-1:0] clr_w,
    input  logic [BIDX_W-1:0] clr_b,
    input  logic              mclr_en,
    input  logic [WIDX_W-1:0] mclr_w,
    input  logic [WIDX_W-1:0] rd_w,
    output logic [WORDS-1:0]  marks,
    output logic [WBITS-1:0]  rd_data
);
    logic [WORDS-1:0][WBITS-1:0] mem;

    // Update the words and marks; sets are applied last so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem   <= '0;
            marks <= '0;
        end else begin
            if (clr_en) begin
                mem[clr_w][clr_b] <= 1'b0;
            end
            if (mclr_en) begin
                marks[mclr_w] <= 1'b0;
            end
            if (set_en) begin
                mem[set_w][set_b] <= 1'b1;
                marks[set_w]      <= 1'b1;
            end
        end
    end

    // Present the word the scanner is working on.
    always_comb begin
        rd_data = mem[rd_w];
    end
endmodule

// File: rtl/rr_scan.sv
// Module rr_scan
// Replay scanner: walks the marked words upward from a floor, clears
// each mark before scanning its word, clears each bit before presenting
// it, and holds the presented source while the dispatcher stalls.
// Assumes marks/rd_data come from rr_bitmap with rd_data showing word rd_w.
module rr_scan
    import rr_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int WBITS = 64,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int BIDX_W = $clog2(WBITS),
    localparam int FL_W   = WIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resend_req,
    input  logic              out_ready,
    input  logic [WORDS-1:0]  marks,
    input  logic [WBITS-1:0]  rd_data,
    output logic [WIDX_W-1:0] rd_w,
    output logic              mclr_en,
    output logic [WIDX_W-1:0] mclr_w,
    output logic              clr_en,
    output logic [WIDX_W-1:0] clr_w,
    output logic [BIDX_W-1:0] clr_b,
    output logic              out_valid,
    output logic [WIDX_W+BIDX_W-1:0] out_src,
    output logic              busy
);
    scan_state_e       state;
    logic [FL_W-1:0]   floor_q;
    logic [WIDX_W-1:0] cur_w;
    logic [BIDX_W-1:0] cur_b;
    logic [WORDS-1:0]  marks_above;
    logic              w_found;
    logic [WIDX_W-1:0] w_idx;
    logic              b_found;
    logic [BIDX_W-1:0] b_idx;

    // Hide marks of words the current scan has already passed.
    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            marks_above[i] = marks[i] && (FL_W'(i) >= floor_q);
        end
    end

    rr_lowfind #(.W(WORDS)) u_word_pick (
        .vec   (marks_above),
        .found (w_found),
        .idx   (w_idx)
    );

    rr_lowfind #(.W(WBITS)) u_bit_pick (
        .vec   (rd_data),
        .found (b_found),
        .idx   (b_idx)
    );

    // Drive bitmap clears and the dispatcher side from the scan state.
    always_comb begin
        rd_w      = cur_w;
        mclr_en   = (state == SCAN_WORD) && w_found;
        mclr_w    = w_idx;
        clr_en    = (state == SCAN_BIT) && b_found;
        clr_w     = cur_w;
        clr_b     = b_idx;
        out_valid = (state == SCAN_EMIT);
        out_src   = {cur_w, cur_b};
        busy      = (state != SCAN_IDLE);
    end

    // Advance the scan: request, word pick, bit pick, handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SCAN_IDLE;
            floor_q <= '0;
            cur_w   <= '0;
            cur_b   <= '0;
        end else begin
            unique case (state)
                SCAN_IDLE: begin
                    if (resend_req) begin
                        floor_q <= '0;
                        state   <= SCAN_WORD;
                    end
                end
                SCAN_WORD: begin
                    if (w_found) begin
                        cur_w   <= w_idx;
                        floor_q <= {1'b0, w_idx} + FL_W'(1);
                        state   <= SCAN_BIT;
                    end else begin
                        state <= SCAN_IDLE;
                    end
                end
                SCAN_BIT: begin
                    if (b_found) begin
                        cur_b <= b_idx;
                        state <= SCAN_EMIT;
                    end else begin
                        state <= SCAN_WORD;
                    end
                end
                SCAN_EMIT: begin
                    if (out_ready) begin
                        state <= SCAN_BIT;
                    end
                end
                default: state <= SCAN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/reject_replay.sv
// Module reject_replay
// Records rejected interrupts in a two-level bitmap and replays them in
// ascending order as forced sends through a valid/ready handshake.
// Assumes WORDS and WBITS are powers of two and IRQ_W exceeds the
// local source index width.
module reject_replay #(
    parameter int WORDS = 32,
    parameter int WBITS = 64,
    parameter int IRQ_W = 24,
    localparam int WIDX_W    = $clog2(WORDS),
    localparam int BIDX_W    = $clog2(WBITS),
    localparam int SRC_COUNT = WORDS * WBITS,
    localparam int SRC_W     = WIDX_W + BIDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] base_irq,
    input  logic             rej_valid,
    input  logic [IRQ_W-1:0] rej_irq,
    input  logic             resend_req,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [SRC_W-1:0] out_src,
    output logic             out_force,
    output logic             busy
);
    logic              rej_hit;
    logic [SRC_W-1:0]  rej_src;
    logic              clr_en;
    logic [WIDX_W-1:0] clr_w;
    logic [BIDX_W-1:0] clr_b;
    logic              mclr_en;
    logic [WIDX_W-1:0] mclr_w;
    logic [WIDX_W-1:0] rd_w;
    logic [WORDS-1:0]  marks;
    logic [WBITS-1:0]  rd_data;

    rr_decode #(.IRQ_W(IRQ_W), .SRC_COUNT(SRC_COUNT)) u_decode (
        .valid (rej_valid),
        .base  (base_irq),
        .irq   (rej_irq),
        .hit   (rej_hit),
        .src   (rej_src)
    );

    rr_bitmap #(.WORDS(WORDS), .WBITS(WBITS)) u_bitmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (rej_hit),
        .set_w   (rej_src[SRC_W-1:BIDX_W]),
        .set_b   (rej_src[BIDX_W-1:0]),
        .clr_en  (clr_en),
        .clr_w   (clr_w),
        .clr_b   (clr_b),
        .mclr_en (mclr_en),
        .mclr_w  (mclr_w),
        .rd_w    (rd_w),
        .marks   (marks),
        .rd_data (rd_data)
    );

    rr_scan #(.WORDS(WORDS), .WBITS(WBITS)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .resend_req (resend_req),
        .out_ready  (out_ready),
        .marks      (marks),
        .rd_data    (rd_data),
        .rd_w       (rd_w),
        .mclr_en    (mclr_en),
        .mclr_w     (mclr_w),
        .clr_en     (clr_en),
        .clr_w      (clr_w),
        .clr_b      (clr_b),
        .out_valid  (out_valid),
        .out_src    (out_src),
        .busy       (busy)
    );

    // Every replay is a forced send.
    always_comb begin
        out_force = out_valid;
    end
endmodule

// File: rtl/rr_checker.sv
// Module rr_checker
// Port-level properties of reject_replay, attached by bind below.
module rr_checker #(
    parameter int SRC_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             resend_req,
    input logic             out_ready,
    input logic             out_valid,
    input logic [SRC_W-1:0] out_src,
    input logic             busy
);
    // R6: a stalled source stays presented.
    a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);

    // R6: a stalled source keeps its index.
    a_r6_hold_src: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_src));

    // R10: reset leaves the block idle and silent.
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !busy);

    // R3: a scan never presents a source in its first busy cycle.
    a_r3_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !out_valid);

    // R9: sources only appear while a scan is in progress.
    a_r9_valid_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R9: a scan only starts from a request.
    a_r9_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !resend_req |=> !busy);
endmodule

bind reject_replay rr_checker #(.SRC_W(SRC_W)) u_rr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .resend_req (resend_req),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_src    (out_src),
    .busy       (busy)
);

// File: tb/tb_reject_replay.sv
module tb_reject_replay;
    localparam int IRQ_W = 24;
    localparam int NSRC  = 2048;
    localparam int BASE  = 'h100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IRQ_W-1:0] base_irq = IRQ_W'(BASE);
    logic             rej_valid = 1'b0;
    logic [IRQ_W-1:0] rej_irq = '0;
    logic             resend_req = 1'b0;
    logic             out_ready = 1'b1;
    logic             out_valid;
    logic [10:0]      out_src;
    logic             out_force;
    logic             busy;

    int checks = 0;
    int fails  = 0;
    int force_bad = 0;
    int hs_total = 0;
    int got[$];
    bit mark [NSRC];

    reject_replay dut (
        .clk (clk), .rst_n (rst_n), .base_irq (base_irq),
        .rej_valid (rej_valid), .rej_irq (rej_irq),
        .resend_req (resend_req), .out_ready (out_ready),
        .out_valid (out_valid), .out_src (out_src),
        .out_force (out_force), .busy (busy)
    );

    always #4 clk = ~clk;

    // Handshake monitor, sampled between edges.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            got.push_back(int'(out_src));
            hs_total++;
            if (!out_force) force_bad++;
        end
    end

    // Three 11-bit local sources per vector: {a, b, c}.
    localparam logic [32:0] VEC [6] = '{
        {11'd0,    11'd1,    11'd63},
        {11'd64,   11'd0,    11'd2047},
        {11'd1000, 11'd999,  11'd1000},
        {11'd127,  11'd128,  11'd5},
        {11'd2047, 11'd2046, 11'd64},
        {11'd300,  11'd300,  11'd300}
    };

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reject(int g);
        rej_irq   = IRQ_W'(g);
        rej_valid = 1'b1;
        tick();
        rej_valid = 1'b0;
    endtask

    task automatic resend_drain();
        resend_req = 1'b1;
        tick();
        resend_req = 1'b0;
        while (busy) tick();
        tick();
    endtask

    task automatic check_seq(string req, int exp[$]);
        check(got.size() == exp.size(), req, "count", got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            check(got[i] == exp[i], req, "source", got[i], exp[i]);
    endtask

    initial begin
        int exp[$];
        tick(); tick();
        check(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        tick();
        check(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);

        // R1 / R4: vector table.
        for (int v = 0; v < 6; v++) begin
            for (int i = 0; i < NSRC; i++) mark[i] = 1'b0;
            got.delete();
            for (int k = 0; k < 3; k++) begin
                int n = int'(VEC[v][k*11 +: 11]);
                mark[n] = 1'b1;
                reject(BASE + n);
            end
            resend_drain();
            exp.delete();
            for (int i = 0; i < NSRC; i++) if (mark[i]) exp.push_back(i);
            check_seq("R1 R4 ordered replay", exp);
            got.delete();
            resend_drain();
            exp.delete();
            check_seq("R4 cleared after scan", exp);
        end

        // R2: out of range.
        got.delete();
        reject(BASE - 1);
        reject(BASE + NSRC);
        reject(BASE + NSRC + 70);
        resend_drain();
        exp.delete();
        check_seq("R2 out of range ignored", exp);

        // R3: empty scan.
        got.delete();
        resend_req = 1'b1;
        tick();
        resend_req = 1'b0;
        check(busy == 1'b1, "R3", "busy after request", int'(busy), 1);
        tick();
        check(busy == 1'b0, "R3", "busy one cycle later", int'(busy), 0);
        check(got.size() == 0, "R3", "emitted count", got.size(), 0);

        // R6 / R7 / R9: stall with rejects and a request mid-scan.
        got.delete();
        reject(BASE + 70);
        reject(BASE + 200);
        out_ready = 1'b0;
        resend_req = 1'b1;
        tick();
        resend_req = 1'b0;
        tick(); tick();
        check(out_valid == 1'b1, "R6", "valid presented", int'(out_valid), 1);
        check(int'(out_src) == 70, "R6", "first source", int'(out_src), 70);
        reject(BASE + 5);
        reject(BASE + 300);
        resend_req = 1'b1;
        tick();
        resend_req = 1'b0;
        tick(); tick();
        check(out_valid == 1'b1, "R6", "valid held in stall", int'(out_valid), 1);
        check(int'(out_src) == 70, "R6", "source held in stall", int'(out_src), 70);
        out_ready = 1'b1;
        while (busy) tick();
        tick();
        exp = '{70, 200, 300};
        check_seq("R7 R9 mid-scan rejects", exp);
        got.delete();
        resend_drain();
        exp = '{5};
        check_seq("R7 passed word waits", exp);

        // R8: reject lands in the cycle its bit is cleared.
        got.delete();
        reject(BASE + 130);
        resend_req = 1'b1;
        tick();
        resend_req = 1'b0;
        tick();
        rej_irq   = IRQ_W'(BASE + 130);
        rej_valid = 1'b1;
        tick();
        rej_valid = 1'b0;
        while (busy) tick();
        tick();
        exp = '{130, 130};
        check_seq("R8 set beats clear", exp);
        got.delete();
        resend_drain();
        exp.delete();
        check_seq("R8 nothing left", exp);

        // R10: reset clears recorded sources.
        got.delete();
        reject(BASE + 12);
        reject(BASE + 1500);
        rst_n = 1'b0;
        tick(); tick();
        check(out_valid == 1'b0 && busy == 1'b0, "R10", "idle in reset",
              int'({out_valid, busy}), 0);
        rst_n = 1'b1;
        tick();
        resend_drain();
        exp.delete();
        check_seq("R10 cleared by reset", exp);

        // R5: every handshake carried the force flag.
        check(force_bad == 0, "R5", "unforced replays", force_bad, 0);
        check(hs_total > 0, "R5", "handshakes seen", hs_total, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule